// File: doc/BRIEF.md
# Control Transfer Record Buffer

This block keeps a rolling history of retired control-transfer instructions. Each time the retire stage reports a jump, it supplies the source PC, the target PC, whether the transfer was direct or indirect, and the destination register index. The block sorts the jump into one of four type codes by linkage and by directness. It drops the record if the matching inhibit bit in a 64-bit control register is set. Otherwise it stores the record at a circular write pointer. The configured depth is a power of two chosen through a legalised depth code.

A freeze input stops all history updates. A stack-emulation mode lets function returns pop the newest record, which turns the buffer into a return-address stack. Software reads entries through an indirect select window. Index 0 always holds the most recent transfer, and the field select picks the source, the target or the type/valid word.

Top module: `ctr_buffer`

## Requirements
- R1: A transfer is linking when its destination register index is non-zero. Compressed jumps present their implied destination index and are sorted the same way. The 4-bit type is 1010 for indirect non-linking, 1011 for direct non-linking, 1110 for indirect linking and 1111 for direct linking.
- R2: An accepted record stores valid=1, source, target and type in the slot at the write pointer. The pointer then advances modulo the configured depth, so the oldest record is overwritten once the buffer is full. Read field 0 returns the source PC, field 1 returns the target PC, and field 2 returns the type in bits [3:0] with the valid flag in bit 4.
- R3: Control bits 42, 43, 46 and 47 inhibit types 1010, 1011, 1110 and 1111 respectively. An inhibited transfer changes nothing.
- R4: Control bits [18:16] hold a depth code, and the depth is MIN_DEPTH shifted left by the code. A requested code above the largest supported code is stored as that largest code. The control read-back shows only the inhibit bits, the mode bit (bit 8) and the legalised depth code. A control write that changes the depth code clears every entry and the write pointer.
- R5: Select values 0x200 to 0x2FF address entries, and index i = select − 0x200 counts back from the newest record. An index at or beyond the depth, a select outside the window, or field 3 reads as zero.
- R6: While freeze is high, no record is written and no pop is applied. A pop requested while frozen is discarded.
- R7: With control bit 8 set (stack mode), a return pop clears the valid flag of the newest entry and decrements the write pointer. With bit 8 clear, pops are ignored.
- R8: When an accepted record and a pop occur in the same cycle, the record is written first and the pop is applied on the next cycle.
- R9: After reset, all entries read as zero, the write pointer is 0, and the control register reads 0: no inhibits, normal mode, smallest depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 64 | Control register write value |
| ctl_rdata | output | 64 | Legalised control register value |
| rec_valid | input | 1 | A control transfer retired this cycle |
| rec_src | input | PC_W | Source PC of the transfer |
| rec_tgt | input | PC_W | Target PC of the transfer |
| rec_indirect | input | 1 | 1 for a register-indirect jump, 0 for a direct jump |
| rec_rd | input | 5 | Destination register index, or the implied index for compressed forms |
| ret_pop | input | 1 | Function-return pop request (stack mode) |
| freeze | input | 1 | Suspend all history updates |
| rd_sel | input | 12 | Indirect select value |
| rd_field | input | 2 | 0 source, 1 target, 2 type/valid |
| rd_data | output | 64 | Selected entry field |

## Verification
The bench builds the block with PC_W=32, MIN_DEPTH=4 and MAX_DEPTH=16, so there are three legal depth codes (4, 8 and 16 entries). Out-of-range code requests, depth-change clears and wrap-around at every depth can therefore be reached within a few dozen records. With a 16-entry ceiling, each check sweep can read every index up to two past the largest depth, which covers the zero-read region beyond the configured depth. Random control writes mix the modes and inhibit patterns with freezes and pops, and the same-cycle record/pop collisions occur often enough to exercise the deferred-pop path.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  localparam int INH_BASE  = 32;
  localparam int MODE_BIT  = 8;
  localparam int DCODE_LSB = 16;
  localparam int DCODE_W   = 3;

  typedef enum logic [3:0] {
    KIND_IND_NOLINK = 4'b1010,
    KIND_DIR_NOLINK = 4'b1011,
    KIND_IND_LINK   = 4'b1110,
    KIND_DIR_LINK   = 4'b1111
  } xfer_kind_e;

  // type = {1, links, 1, direct}
  function automatic logic [3:0] kind_of(input logic indirect, input logic [4:0] rd);
    return {1'b1, (rd != 5'd0), 1'b1, ~indirect};
  endfunction

  // inhibit slot i (0..3) maps to control bit INH_BASE + type code
  function automatic int inh_bit(input int i);
    return INH_BASE + 10 + 4 * (i / 2) + (i % 2);
  endfunction

  function automatic logic [DCODE_W-1:0] legal_code(input logic [DCODE_W-1:0] req,
                                                     input logic [DCODE_W-1:0] maxc);
    return (req > maxc) ? maxc : req;
  endfunction

  function automatic logic [31:0] depth_of(input int min_depth, input logic [DCODE_W-1:0] code);
    return 32'(min_depth) << code;
  endfunction

endpackage

// File: rtl/ctr_ctl_reg.sv
module ctr_ctl_reg
  import ctr_pkg::*;
#(
  parameter int MAX_CODE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [63:0]        wdata,
  output logic [3:0]         inh,
  output logic               stack_mode,
  output logic [DCODE_W-1:0] dcode,
  output logic               depth_chg,
  output logic [63:0]        rdata
);

  logic [DCODE_W-1:0] wcode;
  logic [3:0]         winh;

  assign wcode     = legal_code(wdata[DCODE_LSB +: DCODE_W], DCODE_W'(MAX_CODE));
  assign depth_chg = we && (wcode != dcode);

  always_comb begin
    for (int i = 0; i < 4; i++) winh[i] = wdata[inh_bit(i)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh        <= '0;
      stack_mode <= 1'b0;
      dcode      <= '0;
    end else if (we) begin
      inh        <= winh;
      stack_mode <= wdata[MODE_BIT];
      dcode      <= wcode;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < 4; i++) rdata[inh_bit(i)] = inh[i];
    rdata[MODE_BIT] = stack_mode;
    rdata[DCODE_LSB +: DCODE_W] = dcode;
  end

  assert_depth_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dcode <= DCODE_W'(MAX_CODE));

  assert_code_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[DCODE_LSB +: DCODE_W] > DCODE_W'(MAX_CODE)) |=> dcode == DCODE_W'(MAX_CODE));

endmodule

// File: rtl/ctr_classify.sv
module ctr_classify
  import ctr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rec_valid,
  input  logic       rec_indirect,
  input  logic [4:0] rec_rd,
  input  logic       freeze,
  input  logic [3:0] inh,
  output logic [3:0] kind,
  output logic       accept
);

  logic [1:0] inh_sel;
  logic       blocked;

  assign kind    = kind_of(rec_indirect, rec_rd);
  assign inh_sel = {kind[2], kind[0]};
  assign blocked = inh[inh_sel];
  assign accept  = rec_valid && !freeze && !blocked;

  assert_inhibit_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && inh[{rec_rd != 5'd0, !rec_indirect}]) |-> !accept);

  assert_freeze_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !accept);

endmodule

// File: rtl/ctr_store.sv
module ctr_store
  import ctr_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int MIN_DEPTH = 4,
  parameter int MAX_DEPTH = 16,
  localparam int PTR_W    = $clog2(MAX_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [DCODE_W-1:0] dcode,
  input  logic               wr_fire,
  input  logic [PC_W-1:0]    wr_src,
  input  logic [PC_W-1:0]    wr_tgt,
  input  logic [3:0]         wr_kind,
  input  logic               pop_req,
  input  logic               stack_mode,
  input  logic               freeze,
  output logic [PTR_W-1:0]   wrptr,
  output logic               ent_v   [MAX_DEPTH],
  output logic [PC_W-1:0]    ent_src [MAX_DEPTH],
  output logic [PC_W-1:0]    ent_tgt [MAX_DEPTH],
  output logic [3:0]         ent_kind[MAX_DEPTH]
);

  logic [PTR_W-1:0] mask;
  logic [PTR_W-1:0] top;
  logic             pend;
  logic             pop_any;
  logic             pop_fire;
  logic             pend_d;

  assign mask     = PTR_W'(depth_of(MIN_DEPTH, dcode) - 32'd1);
  assign top      = (wrptr - PTR_W'(1)) & mask;
  assign pop_any  = (pop_req || pend) && stack_mode && !freeze && !clr;
  assign pop_fire = pop_any && !wr_fire;
  assign pend_d   = pop_any && wr_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrptr <= '0;
      pend  <= 1'b0;
    end else if (clr) begin
      wrptr <= '0;
      pend  <= 1'b0;
    end else begin
      pend <= pend_d;
      if (wr_fire)       wrptr <= (wrptr + PTR_W'(1)) & mask;
      else if (pop_fire) wrptr <= top;
    end
  end

  for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[g]    <= 1'b0;
        ent_src[g]  <= '0;
        ent_tgt[g]  <= '0;
        ent_kind[g] <= '0;
      end else if (clr) begin
        ent_v[g]    <= 1'b0;
        ent_src[g]  <= '0;
        ent_tgt[g]  <= '0;
        ent_kind[g] <= '0;
      end else if (wr_fire && wrptr == PTR_W'(g)) begin
        ent_v[g]    <= 1'b1;
        ent_src[g]  <= wr_src;
        ent_tgt[g]  <= wr_tgt;
        ent_kind[g] <= wr_kind;
      end else if (pop_fire && top == PTR_W'(g)) begin
        ent_v[g]    <= 1'b0;
      end
    end
  end

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrptr & ~mask) == '0);

  assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !clr) |=> ent_v[$past(wrptr)]);

  assert_pop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (wrptr == (($past(wrptr) - PTR_W'(1)) & $past(mask))) && !ent_v[$past(top)]);

  assert_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && pop_req && stack_mode && !freeze && !clr) |=> pend);

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clr) |=> $stable(wrptr));

  assert_normal_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stack_mode |-> !pop_fire);

endmodule

// File: rtl/ctr_read.sv
module ctr_read
  import ctr_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int MIN_DEPTH = 4,
  parameter int MAX_DEPTH = 16,
  localparam int PTR_W    = $clog2(MAX_DEPTH)
) (
  input  logic [11:0]        rd_sel,
  input  logic [1:0]         rd_field,
  input  logic [DCODE_W-1:0] dcode,
  input  logic [PTR_W-1:0]   wrptr,
  input  logic               ent_v   [MAX_DEPTH],
  input  logic [PC_W-1:0]    ent_src [MAX_DEPTH],
  input  logic [PC_W-1:0]    ent_tgt [MAX_DEPTH],
  input  logic [3:0]         ent_kind[MAX_DEPTH],
  output logic [63:0]        rd_data
);

  logic [31:0]      depth_n;
  logic [PTR_W-1:0] mask;
  logic [7:0]       idx;
  logic             in_win;
  logic [PTR_W-1:0] slot;

  assign depth_n = depth_of(MIN_DEPTH, dcode);
  assign mask    = PTR_W'(depth_n - 32'd1);
  assign idx     = rd_sel[7:0];
  assign in_win  = (rd_sel[11:8] == 4'h2) && ({24'd0, idx} < depth_n);
  assign slot    = (wrptr - PTR_W'(1) - PTR_W'(idx)) & mask;

  always_comb begin
    rd_data = '0;
    if (in_win) begin
      case (rd_field)
        2'd0:    rd_data[PC_W-1:0] = ent_src[slot];
        2'd1:    rd_data[PC_W-1:0] = ent_tgt[slot];
        2'd2:    rd_data[4:0]      = {ent_v[slot], ent_kind[slot]};
        default: rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/ctr_buffer.sv
module ctr_buffer
  import ctr_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int MIN_DEPTH = 4,
  parameter int MAX_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic [63:0]     ctl_wdata,
  output logic [63:0]     ctl_rdata,
  input  logic            rec_valid,
  input  logic [PC_W-1:0] rec_src,
  input  logic [PC_W-1:0] rec_tgt,
  input  logic            rec_indirect,
  input  logic [4:0]      rec_rd,
  input  logic            ret_pop,
  input  logic            freeze,
  input  logic [11:0]     rd_sel,
  input  logic [1:0]      rd_field,
  output logic [63:0]     rd_data
);

  localparam int PTR_W    = $clog2(MAX_DEPTH);
  localparam int MAX_CODE = $clog2(MAX_DEPTH / MIN_DEPTH);

  logic [3:0]         inh;
  logic               stack_mode;
  logic [DCODE_W-1:0] dcode;
  logic               depth_chg;
  logic [3:0]         kind;
  logic               accept;
  logic [PTR_W-1:0]   wrptr;
  logic               ent_v   [MAX_DEPTH];
  logic [PC_W-1:0]    ent_src [MAX_DEPTH];
  logic [PC_W-1:0]    ent_tgt [MAX_DEPTH];
  logic [3:0]         ent_kind[MAX_DEPTH];

  ctr_ctl_reg #(.MAX_CODE(MAX_CODE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .inh(inh), .stack_mode(stack_mode), .dcode(dcode),
    .depth_chg(depth_chg), .rdata(ctl_rdata)
  );

  ctr_classify u_cls (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid),
    .rec_indirect(rec_indirect), .rec_rd(rec_rd), .freeze(freeze),
    .inh(inh), .kind(kind), .accept(accept)
  );

  ctr_store #(.PC_W(PC_W), .MIN_DEPTH(MIN_DEPTH), .MAX_DEPTH(MAX_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(depth_chg), .dcode(dcode),
    .wr_fire(accept), .wr_src(rec_src), .wr_tgt(rec_tgt), .wr_kind(kind),
    .pop_req(ret_pop), .stack_mode(stack_mode), .freeze(freeze),
    .wrptr(wrptr), .ent_v(ent_v), .ent_src(ent_src), .ent_tgt(ent_tgt),
    .ent_kind(ent_kind)
  );

  ctr_read #(.PC_W(PC_W), .MIN_DEPTH(MIN_DEPTH), .MAX_DEPTH(MAX_DEPTH)) u_read (
    .rd_sel(rd_sel), .rd_field(rd_field), .dcode(dcode), .wrptr(wrptr),
    .ent_v(ent_v), .ent_src(ent_src), .ent_tgt(ent_tgt), .ent_kind(ent_kind),
    .rd_data(rd_data)
  );

  assert_kind_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ent_kind[($past(wrptr))] == {1'b1, $past(rec_rd) != 5'd0, 1'b1, !$past(rec_indirect)}
               || $past(depth_chg));

endmodule

// File: tb/ctr_buffer_bench.sv
module ctr_buffer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PC_W = 32, MIN_D = 4, MAX_D = 16, MAXC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0; logic [63:0] ctl_wdata = '0; logic [63:0] ctl_rdata;
  logic rec_valid = 0; logic [PC_W-1:0] rec_src = '0, rec_tgt = '0;
  logic rec_indirect = 0; logic [4:0] rec_rd = '0;
  logic ret_pop = 0, freeze = 0;
  logic [11:0] rd_sel = '0; logic [1:0] rd_field = '0; logic [63:0] rd_data;

  ctr_buffer #(.PC_W(PC_W), .MIN_DEPTH(MIN_D), .MAX_DEPTH(MAX_D)) u_ctr_buffer (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .rec_valid(rec_valid), .rec_src(rec_src), .rec_tgt(rec_tgt), .rec_indirect(rec_indirect),
    .rec_rd(rec_rd), .ret_pop(ret_pop), .freeze(freeze), .rd_sel(rd_sel), .rd_field(rd_field),
    .rd_data(rd_data));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  bit m_v[MAX_D]; logic [PC_W-1:0] m_src[MAX_D], m_tgt[MAX_D]; logic [3:0] m_ty[MAX_D];
  int m_wp = 0; bit m_pend = 0; bit [3:0] m_inh = 0; bit m_mode = 0; int m_code = 0;

  function automatic logic [3:0] exp_kind(bit ind, logic [4:0] rd);
    if (rd == 0) return ind ? 4'hA : 4'hB;
    return ind ? 4'hE : 4'hF;
  endfunction
  function automatic int exp_depth(int code); return MIN_D * (2 ** code); endfunction
  function automatic int legal(int c); return (c > MAXC) ? MAXC : c; endfunction
  function automatic int inh_idx(logic [3:0] k);
    case (k) 4'hA: return 0; 4'hB: return 1; 4'hE: return 2; default: return 3; endcase
  endfunction
  function automatic logic [63:0] exp_ctl();
    logic [63:0] r = '0;
    r[42] = m_inh[0]; r[43] = m_inh[1]; r[46] = m_inh[2]; r[47] = m_inh[3];
    r[8] = m_mode; r[18:16] = 3'(m_code);
    return r;
  endfunction
  function automatic logic [63:0] exp_read(int sel, int fld);
    int d, i, s;
    d = exp_depth(m_code);
    if (sel < 'h200 || sel > 'h2FF) return 64'd0;
    i = sel - 'h200;
    if (i >= d) return 64'd0;
    s = (m_wp + d - 1 - i) % d;
    case (fld)
      0: return 64'(m_src[s]);
      1: return 64'(m_tgt[s]);
      2: return 64'({m_v[s], m_ty[s]});
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < MAX_D; i++) begin m_v[i] = 0; m_src[i] = '0; m_tgt[i] = '0; m_ty[i] = '0; end
    m_wp = 0; m_pend = 0;
  endtask

  task automatic step(bit rv, logic [PC_W-1:0] s, logic [PC_W-1:0] t, bit ind, logic [4:0] rd,
                      bit pop, bit frz, bit cwe, logic [63:0] cwd);
    bit acc, clr, pany; logic [3:0] k; int d, top;
    rec_valid = rv; rec_src = s; rec_tgt = t; rec_indirect = ind; rec_rd = rd;
    ret_pop = pop; freeze = frz; ctl_we = cwe; ctl_wdata = cwd;
    @(posedge clk);
    k = exp_kind(ind, rd);
    acc = rv && !frz && !m_inh[inh_idx(k)];
    clr = cwe && (legal(int'(cwd[18:16])) != m_code);
    d = exp_depth(m_code);
    if (clr) model_clear();
    else begin
      pany = (pop || m_pend) && m_mode && !frz;
      m_pend = pany && acc;
      if (acc) begin
        m_v[m_wp] = 1; m_src[m_wp] = s; m_tgt[m_wp] = t; m_ty[m_wp] = k;
        m_wp = (m_wp + 1) % d;
      end else if (pany) begin
        top = (m_wp + d - 1) % d;
        m_v[top] = 0; m_wp = top;
      end
    end
    if (cwe) begin
      m_inh = {cwd[47], cwd[46], cwd[43], cwd[42]}; m_mode = cwd[8];
      m_code = legal(int'(cwd[18:16]));
    end
    @(negedge clk);
    rec_valid = 0; ret_pop = 0; ctl_we = 0;
  endtask

  task automatic rec(logic [PC_W-1:0] s, logic [PC_W-1:0] t, bit ind, logic [4:0] rd);
    step(1, s, t, ind, rd, 0, 0, 0, '0);
  endtask
  task automatic wctl(logic [63:0] v); step(0, '0, '0, 0, 0, 0, 0, 1, v); endtask

  task automatic check_all(string req);
    int sels[4] = '{'h1FF, 'h300, 'h2FF, 'h000};
    chk(ctl_rdata === exp_ctl(), req, ctl_rdata, exp_ctl());
    for (int i = 0; i < MAX_D + 2; i++)
      for (int f = 0; f < 3; f++) begin
        rd_sel = 12'('h200 + i); rd_field = 2'(f); #0.02;
        chk(rd_data === exp_read('h200 + i, f), req, rd_data, exp_read('h200 + i, f));
      end
    foreach (sels[j]) begin
      rd_sel = 12'(sels[j]); rd_field = 2'(j % 3); #0.02;
      chk(rd_data === 64'd0, {req, " R5 outside"}, rd_data, 64'd0);
    end
    rd_sel = 12'h200; rd_field = 2'd3; #0.02;
    chk(rd_data === 64'd0, {req, " R5 field3"}, rd_data, 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd20240611);
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R9 reset");

    // R1: the four kinds; rd=1 stands for a compressed linking form
    rec(32'h1000, 32'h2000, 1, 5'd0);
    rec(32'h1004, 32'h2004, 0, 5'd0);
    rec(32'h1008, 32'h2008, 1, 5'd1);
    rec(32'h100C, 32'h200C, 0, 5'd5);
    check_all("R1 kinds");
    rd_sel = 12'h200; rd_field = 2; #0.02;
    chk(rd_data === 64'h1F, "R1 direct-link newest", rd_data, 64'h1F);

    // R3: inhibit direct non-linking (bit 43), then indirect linking (bit 46)
    wctl(64'h1 << 43);
    rec(32'h3000, 32'h4000, 0, 5'd0);
    rec(32'h3004, 32'h4004, 1, 5'd0);
    check_all("R3 inhibit 43");
    wctl(64'h1 << 46);
    rec(32'h3008, 32'h4008, 1, 5'd3);
    rec(32'h300C, 32'h400C, 0, 5'd0);
    check_all("R3 inhibit 46");

    // R4: illegal depth code clamps and clears; then depth 8
    wctl(64'(7) << 16);
    check_all("R4 clamp");
    wctl(64'(1) << 16);
    check_all("R4 depth8 clear");

    // R2/R5: wrap at depth 8
    for (int i = 0; i < 11; i++) rec(32'h5000 + 32'(4*i), 32'h6000 + 32'(4*i), i[0], 5'(i));
    check_all("R2 wrap");

    // R6: freeze blocks records and pops
    wctl((64'(1) << 16) | (64'h1 << 8));
    step(1, 32'h7000, 32'h7100, 0, 1, 0, 1, 0, '0);
    step(0, '0, '0, 0, 0, 1, 1, 0, '0);
    check_all("R6 freeze");

    // R7: pops in stack mode, and ignored in normal mode
    step(0, '0, '0, 0, 0, 1, 0, 0, '0);
    step(0, '0, '0, 0, 0, 1, 0, 0, '0);
    check_all("R7 stack pop");
    wctl(64'(1) << 16);
    step(0, '0, '0, 0, 0, 1, 0, 0, '0);
    check_all("R7 normal ignores pop");

    // R8: record and pop together
    wctl((64'(1) << 16) | (64'h1 << 8));
    step(1, 32'h8000, 32'h8100, 1, 1, 1, 0, 0, '0);
    check_all("R8 record first");
    step(0, '0, '0, 0, 0, 0, 0, 0, '0);
    check_all("R8 pop next cycle");

    // random mix
    for (int n = 0; n < 2500; n++) begin
      bit rv, pop, frz, cwe; logic [63:0] cwd;
      rv  = ($urandom % 100) < 60;
      pop = ($urandom % 100) < 25;
      frz = ($urandom % 100) < 10;
      cwe = ($urandom % 100) < 3;
      cwd = {$urandom, $urandom};
      step(rv, $urandom, $urandom, $urandom % 2, (($urandom % 3) == 0) ? 5'd0 : 5'($urandom),
           pop, frz, cwe, cwd);
      check_all("R2 R3 R6 R7 R8 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule